// File: doc/BRIEF.md
# Graded PLL Phase-Error Width Monitor

This block watches the error pulse produced by a PLL phase detector and measures how many reference clock cycles each pulse stays high. Four duration limits are compared against the running width of the current pulse. When a pulse outlasts a limit, the flag for that limit is set and stays set, so software or a readout path can later see the worst phase slip since the last clear. The flag word is cleared by a one-cycle clear strobe, for example when the word is read.

The limits are not in ascending order across the flag bits. With the default settings and a 7.2 MHz reference, bit 3 marks the shortest slip, 4 cycles or about 0.55 us. Bit 0 marks 8 cycles (about 1.11 us), bit 1 marks 16 cycles (about 2.22 us) and bit 2 marks 24 cycles (about 3.33 us). The error pulse must already be in the reference clock domain. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `pll_slip_monitor`

## Requirements
- R1: After reset is released, `flags_o` reads 4'b0000.
- R2: A flag bit sets at the rising clock edge on which `perr_i` has been sampled high on more consecutive edges than that bit's limit. The limits are bit 0 = 8, bit 1 = 16, bit 2 = 24 and bit 3 = 4. The new value is visible on `flags_o` straight after that edge.
- R3: A pulse sampled high on exactly as many consecutive edges as a bit's limit does not set that bit.
- R4: Once set, a flag bit stays 1 while `clr_i` is low, whatever `perr_i` does.
- R5: `clr_i` sampled high at a clock edge zeroes every flag bit whose limit is not exceeded at that edge.
- R6: If `clr_i` is high at the same edge on which a bit's limit is exceeded, that bit ends up 1.
- R7: The width count restarts from zero whenever `perr_i` is sampled low, so separate short pulses never add up to a longer one.
- R8: The width count saturates one above the largest limit and never wraps. A pulse of any length keeps every limit exceeded from its crossing edge to its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| perr_i | input | 1 | Phase-detector error pulse, synchronous to clk_i |
| clr_i | input | 1 | Clear strobe for the flag word |
| flags_o | output | 4 | Sticky slip flags, one per duration limit |

## Verification
On every cycle, the assertions check the following:
- the width counter steps by one, saturates and returns to zero at the right times;
- no flag drops without a clear;
- a flag that rises always has a count above its limit behind it;
- after a clear, only flags whose limit is currently exceeded remain set.

Some behaviour shows up only in the bench scenarios, which compare against a behavioural model at every cycle:
- the exact edge of each crossing at the limit boundaries, including the exact-limit pulses that must not set a bit;
- the non-ascending bit order;
- the case where a clear and a crossing fall on the same edge;
- the absence of wrap on a pulse longer than the counter's natural range.

// File: rtl/slip_pkg.sv
package slip_pkg;

  // Bits needed to hold values 0..n
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  localparam int unsigned DEF_FLAGS = 4;

endpackage

// File: rtl/slip_rst_sync.sv
module slip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/slip_run_counter.sv
module slip_run_counter #(
  parameter int unsigned CW  = 5,
  parameter int unsigned SAT = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          perr_i,
  output logic [CW-1:0] cnt_d_o,
  output logic [CW-1:0] cnt_q_o
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // The register moves when the pulse is low (restart) or while still below the ceiling
  always_comb begin
    cnt_en = !perr_i || (cnt_q != SAT_V);
    if (!perr_i) cnt_d = '0;
    else if (cnt_q == SAT_V) cnt_d = cnt_q;
    else cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_d_o = cnt_d;
  assign cnt_q_o = cnt_q;

  AST_CNT_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT_V); // R8
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_i |=> cnt_q == '0); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_i && cnt_q != SAT_V) |=> cnt_q == $past(cnt_q) + CW'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_i && cnt_q == SAT_V) |=> cnt_q == SAT_V); // R8
endmodule

// File: rtl/slip_flag_bank.sv
module slip_flag_bank #(
  parameter int unsigned NF = 4,
  parameter int unsigned CW = 5,
  parameter int unsigned THRESH [NF] = '{8, 16, 24, 4}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] cnt_q_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] hit;
  logic [NF-1:0] flags_q;
  logic [NF-1:0] flags_d;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    localparam logic [CW-1:0] LIMIT = CW'(THRESH[i]);
    assign hit[i] = cnt_d_i > LIMIT;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !clr_i) |=> flags_q[i]); // R4
    AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[i]) |-> cnt_q_i > LIMIT); // R2
    AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (!flags_q[i] || cnt_q_i > LIMIT)); // R5
  end

  // A crossing on the clear edge survives the clear
  always_comb begin
    flags_d = (clr_i ? '0 : flags_q) | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pll_slip_monitor.sv
module pll_slip_monitor #(
  parameter int unsigned N_FLAG = slip_pkg::DEF_FLAGS,
  parameter int unsigned THRESH [N_FLAG] = '{8, 16, 24, 4},
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              perr_i,
  input  logic              clr_i,
  output logic [N_FLAG-1:0] flags_o
);
  function automatic int unsigned peak_limit();
    int unsigned m = 0;
    for (int k = 0; k < int'(N_FLAG); k++) if (THRESH[k] > m) m = THRESH[k];
    return m;
  endfunction

  localparam int unsigned SAT = peak_limit() + 1;
  localparam int unsigned CW  = slip_pkg::count_bits(SAT);

  logic          rst_n;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;

  slip_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  slip_run_counter #(.CW(CW), .SAT(SAT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .perr_i (perr_i),
    .cnt_d_o(cnt_d),
    .cnt_q_o(cnt_q)
  );

  slip_flag_bank #(.NF(N_FLAG), .CW(CW), .THRESH(THRESH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (clr_i),
    .cnt_d_i(cnt_d),
    .cnt_q_i(cnt_q),
    .flags_o(flags_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |=> (flags_o == '0 || rst_n)); // R1
endmodule

// File: tb/sim_pll_slip_monitor.sv
`timescale 1ns/1ps
module sim_pll_slip_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       perr_i;
  logic       clr_i;
  logic [3:0] flags_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit live  = 1'b0;
  string phase = "R1";

  int thr [4] = '{8, 16, 24, 4};
  int run = 0;
  logic [3:0] mflags = '0;

  pll_slip_monitor u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .perr_i (perr_i),
    .clr_i  (clr_i),
    .flags_o(flags_o)
  );

  always #2.5 clk_i = ~clk_i;

  // Behavioural reference: length of the current high run, then sticky flags
  always @(posedge clk_i) begin
    logic [3:0] hit;
    if (!rst_ni) begin
      run = 0;
      mflags = '0;
    end else begin
      run = perr_i ? run + 1 : 0;
      for (int k = 0; k < 4; k++) hit[k] = (run > thr[k]);
      mflags = clr_i ? hit : (mflags | hit);
    end
  end

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: flags=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (live && !done) check(phase, flags_o, mflags);

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      perr_i = 1'b0; clr_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      perr_i = 1'b1; @(negedge clk_i);
    end
    perr_i = 1'b0;
  endtask

  task automatic clear_all();
    clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: flags=%b expected=run end", flags_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; perr_i = 1'b0; clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(4);
    live = 1'b1;
    check("R1", flags_o, 4'b0000);

    phase = "R3";
    pulse(4);  check("R3", flags_o, 4'b0000);   // exactly the bit 3 limit
    idle(2);
    phase = "R2";
    pulse(5);  check("R2", flags_o, 4'b1000);
    idle(1);
    phase = "R5";
    clear_all(); check("R5", flags_o, 4'b0000);
    idle(1);

    phase = "R3";
    pulse(8);  check("R3", flags_o, 4'b1000);   // bit 0 limit not exceeded
    idle(1); clear_all();
    phase = "R2";
    pulse(9);  check("R2", flags_o, 4'b1001);
    phase = "R4";
    idle(10);  check("R4", flags_o, 4'b1001);
    pulse(2);  check("R4", flags_o, 4'b1001);
    idle(1); clear_all(); idle(1);

    phase = "R7";
    for (int k = 0; k < 3; k++) begin pulse(4); idle(1); end
    check("R7", flags_o, 4'b0000);

    phase = "R3";
    pulse(24); check("R3", flags_o, 4'b1011);
    idle(1); clear_all();
    phase = "R2";
    pulse(17); check("R2", flags_o, 4'b1011);
    idle(1); clear_all();
    pulse(25); check("R2", flags_o, 4'b1111);
    idle(1);

    // Clear on the very edge where the fifth high sample crosses bit 3
    phase = "R6";
    for (int k = 0; k < 4; k++) begin perr_i = 1'b1; @(negedge clk_i); end
    clr_i = 1'b1; perr_i = 1'b1; @(negedge clk_i);
    clr_i = 1'b0; perr_i = 1'b0;
    check("R6", flags_o, 4'b1000);
    idle(1); clear_all(); idle(1);

    // Long pulse past the counter's natural range, clearing each of the last 9 edges
    phase = "R8";
    for (int k = 0; k < 34; k++) begin
      perr_i = 1'b1; clr_i = (k >= 25); @(negedge clk_i);
    end
    perr_i = 1'b0; clr_i = 1'b0;
    check("R8", flags_o, 4'b1111);
    idle(1);
    phase = "R5";
    clear_all(); check("R5", flags_o, 4'b0000);
    idle(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule